// File: doc/BRIEF.md
# ADC Register Bring-Up Sequencer

This block configures an external high-speed converter over a four-wire serial link after power-up. On a start request it issues a soft reset to the converter. It then programs four configuration registers: sample number format, output lane mode, and the high and low halves of a 16-bit test pattern. After every configuration write except the reset it reads the same register back and compares the returned byte with the value it wrote. A sticky error flag records any difference. A one-cycle done pulse marks the end of the sequence.

A second command, accepted only when the block is idle, rewrites the lane-mode register on its own and then verifies it. This lets the system turn the converter's test pattern off once word alignment has finished. The serial link runs in mode 0 with an active-low select. Each frame is 16 bits: an address byte, then a data byte, both MSB first. Bit 15 of the frame set means a read.

States of the controller: IDLE (waits for a command), WR_GO (launches a write frame), WR_WAIT (waits for the write frame to finish), RD_GO (launches a readback frame), RD_WAIT (waits for the readback frame), CHECK (compares the returned byte), ADV (moves to the next step or ends), FIN (pulses done). Transitions:
- IDLE→WR_GO on start or rewrite.
- WR_GO→WR_WAIT.
- WR_WAIT→RD_GO when the frame ends, or WR_WAIT→ADV for the soft reset step.
- RD_GO→RD_WAIT.
- RD_WAIT→CHECK when the frame ends.
- CHECK→ADV.
- ADV→WR_GO while steps remain, otherwise ADV→FIN.
- FIN→IDLE.

Top module: `adc_init_seq`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, mosi_o is 0, and busy_o, done_o and err_o are all 0.
- R2: Every frame is exactly 16 SCLK pulses while cs_n_o is low, MSB first. MOSI changes only while SCLK is low, and SCLK is low whenever cs_n_o is high. The first byte of a frame is {rd, addr[6:0]} and the second is the data byte.
- R3: Each SCLK high phase lasts SYS_CLK_HZ/(2*SCLK_HZ) system clocks. cs_n_o stays high for at least one full SCLK period between frames.
- R4: A start performs exactly nine frames, in this order as 16-bit words: 0x0080, 0x0120, 0x8100, 0x0215, 0x8200, {0x03, pattern[15:8]}, 0x8300, {0x04, pattern[7:0]}, 0x8400. The soft reset (register 0x00) is not read back.
- R5: A readback frame is the written address with bit 7 set and a data byte of 0x00. The byte received during its data phase is compared with the byte written just before.
- R6: pattern_i is captured in the cycle a start is accepted. Changes to it during the sequence have no effect on the frames.
- R7: A rewrite command performs exactly two frames: {0x02, 0x15} when test_en_i is 1, or {0x02, 0x11} when it is 0, followed by 0x8200. test_en_i is captured when the command is accepted.
- R8: Any readback mismatch sets err_o. err_o stays set through the end of the sequence and while idle. It is cleared only in the cycle a new start or rewrite is accepted.
- R9: busy_o rises in the cycle after a command is accepted and stays high up to and including the cycle of done_o. done_o is high for exactly one cycle per sequence.
- R10: start_i and rewrite_i are ignored while busy_o is high. If both arrive together while idle, the full sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the full bring-up sequence (idle only) |
| rewrite_i | input | 1 | Rewrite and verify only the lane-mode register (idle only) |
| pattern_i | input | 16 | Test pattern to load into the converter |
| test_en_i | input | 1 | Test pattern on (1) or off (0) for the rewrite command |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sticky readback mismatch flag |

## Verification
busy_o is due one clock after the edge that takes the command, so the bench drives commands on falling edges and samples busy_o on the next falling edge. Each frame takes 35 SCLK half periods: one lead-in half, 32 data halves and two select-high halves. A few controller cycles follow each frame, so done_o arrives many clocks after the command. The bench polls done_o on falling edges and then checks the following falling edge for done_o and busy_o both low. Frame contents, SCLK phase lengths and select-high gaps are taken at the pins by a converter model and falling-edge monitors, then compared after each sequence against words built from the requirements.

// File: rtl/adc_init_pkg.sv
package adc_init_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_GO,
        S_WR_WAIT,
        S_RD_GO,
        S_RD_WAIT,
        S_CHECK,
        S_ADV,
        S_FIN
    } seq_state_t;

    localparam int FRAME_BITS = 16;
    localparam int STEP_W     = 3;

    localparam logic [STEP_W-1:0] STEP_SRST = 3'd0;
    localparam logic [STEP_W-1:0] STEP_FMT  = 3'd1;
    localparam logic [STEP_W-1:0] STEP_LANE = 3'd2;
    localparam logic [STEP_W-1:0] STEP_PHI  = 3'd3;
    localparam logic [STEP_W-1:0] STEP_PLO  = 3'd4;

    localparam logic [6:0] ADR_SRST = 7'h00;
    localparam logic [6:0] ADR_FMT  = 7'h01;
    localparam logic [6:0] ADR_LANE = 7'h02;
    localparam logic [6:0] ADR_PHI  = 7'h03;
    localparam logic [6:0] ADR_PLO  = 7'h04;

    localparam logic [7:0] VAL_SRST     = 8'h80;
    localparam logic [7:0] VAL_TWOS     = 8'h20;
    localparam logic [7:0] VAL_LANE_TST = 8'h15;
    localparam logic [7:0] VAL_LANE_RUN = 8'h11;

endpackage

// File: rtl/adc_step_table.sv
module adc_step_table
    import adc_init_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [15:0]       pattern_i,
    input  logic              test_en_i,
    output logic [6:0]        addr_o,
    output logic [7:0]        data_o,
    output logic              verify_o
);

    always_comb begin
        addr_o   = ADR_SRST;
        data_o   = VAL_SRST;
        verify_o = 1'b1;
        unique case (step_i)
            STEP_SRST: begin
                addr_o   = ADR_SRST;
                data_o   = VAL_SRST;
                verify_o = 1'b0;
            end
            STEP_FMT: begin
                addr_o = ADR_FMT;
                data_o = VAL_TWOS;
            end
            STEP_LANE: begin
                addr_o = ADR_LANE;
                data_o = test_en_i ? VAL_LANE_TST : VAL_LANE_RUN;
            end
            STEP_PHI: begin
                addr_o = ADR_PHI;
                data_o = pattern_i[15:8];
            end
            STEP_PLO: begin
                addr_o = ADR_PLO;
                data_o = pattern_i[7:0];
            end
            default: begin
                addr_o   = ADR_SRST;
                data_o   = VAL_SRST;
                verify_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
    parameter int HALF_DIV = 5,
    parameter int BITS     = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [BITS-1:0] word_i,
    input  logic            miso_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [7:0]      rx_o,
    output logic            sclk_o,
    output logic            mosi_o,
    output logic            cs_n_o
);

    localparam int LAST_HALF = 2 * BITS;
    localparam int END_HALF  = LAST_HALF + 2;
    localparam int HC_W      = $clog2(END_HALF + 1);
    localparam int DC_W      = $clog2(HALF_DIV + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(LAST_HALF);
    localparam logic [HC_W-1:0] HC_END  = HC_W'(END_HALF);
    localparam logic [DC_W-1:0] DC_TOP  = DC_W'(HALF_DIV - 1);

    logic            active;
    logic [HC_W-1:0] hcnt;
    logic [DC_W-1:0] dcnt;
    logic [BITS-1:0] tx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            hcnt   <= '0;
            dcnt   <= '0;
            tx     <= '0;
            rx_o   <= '0;
            sclk_o <= 1'b0;
            cs_n_o <= 1'b1;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                if (go_i) begin
                    active <= 1'b1;
                    cs_n_o <= 1'b0;
                    tx     <= word_i;
                    hcnt   <= '0;
                    dcnt   <= '0;
                end
            end else if (dcnt == DC_TOP) begin
                dcnt <= '0;
                hcnt <= hcnt + 1'b1;
                if (hcnt < HC_LAST) begin
                    if (!hcnt[0]) begin
                        sclk_o <= 1'b1;
                        rx_o   <= {rx_o[6:0], miso_i};
                    end else begin
                        sclk_o <= 1'b0;
                        tx     <= {tx[BITS-2:0], 1'b0};
                    end
                end else if (hcnt == HC_LAST) begin
                    cs_n_o <= 1'b1;
                end else if (hcnt == HC_END) begin
                    active <= 1'b0;
                    done_o <= 1'b1;
                end
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

    assign mosi_o = tx[BITS-1];
    assign busy_o = active;

    // R2
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R2
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !active);

endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq
    import adc_init_pkg::*;
#(
    parameter int SYS_CLK_HZ = 125_000_000,
    parameter int SCLK_HZ    = 12_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rewrite_i,
    input  logic [15:0] pattern_i,
    input  logic        test_en_i,
    input  logic        miso_i,
    output logic        sclk_o,
    output logic        mosi_o,
    output logic        cs_n_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o
);

    localparam int RAW_DIV  = SYS_CLK_HZ / (2 * SCLK_HZ);
    localparam int HALF_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;

    seq_state_t st, nxt;

    logic [STEP_W-1:0]     step, last_step;
    logic [15:0]           pat_q;
    logic                  te_q;
    logic [6:0]            cur_addr;
    logic [7:0]            cur_data;
    logic                  cur_verify;
    logic                  eng_go, eng_busy, eng_done;
    logic [FRAME_BITS-1:0] eng_word;
    logic [7:0]            eng_rx;

    adc_step_table u_table (
        .step_i    (step),
        .pattern_i (pat_q),
        .test_en_i (te_q),
        .addr_o    (cur_addr),
        .data_o    (cur_data),
        .verify_o  (cur_verify)
    );

    adc_spi_frame #(
        .HALF_DIV (HALF_DIV),
        .BITS     (FRAME_BITS)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (eng_go),
        .word_i (eng_word),
        .miso_i (miso_i),
        .busy_o (eng_busy),
        .done_o (eng_done),
        .rx_o   (eng_rx),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .cs_n_o (cs_n_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:    if (start_i || rewrite_i) nxt = S_WR_GO;
            S_WR_GO:   nxt = S_WR_WAIT;
            S_WR_WAIT: if (eng_done) nxt = cur_verify ? S_RD_GO : S_ADV;
            S_RD_GO:   nxt = S_RD_WAIT;
            S_RD_WAIT: if (eng_done) nxt = S_CHECK;
            S_CHECK:   nxt = S_ADV;
            S_ADV:     nxt = (step == last_step) ? S_FIN : S_WR_GO;
            S_FIN:     nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step      <= STEP_SRST;
            last_step <= STEP_PLO;
            pat_q     <= '0;
            te_q      <= 1'b1;
            err_o     <= 1'b0;
        end else begin
            if (st == S_IDLE) begin
                if (start_i) begin
                    step      <= STEP_SRST;
                    last_step <= STEP_PLO;
                    pat_q     <= pattern_i;
                    te_q      <= 1'b1;
                    err_o     <= 1'b0;
                end else if (rewrite_i) begin
                    step      <= STEP_LANE;
                    last_step <= STEP_LANE;
                    te_q      <= test_en_i;
                    err_o     <= 1'b0;
                end
            end
            if (st == S_CHECK && eng_rx != cur_data) err_o <= 1'b1;
            if (st == S_ADV && step != last_step) step <= step + 1'b1;
        end
    end

    always_comb begin
        eng_go   = 1'b0;
        eng_word = '0;
        busy_o   = (st != S_IDLE);
        done_o   = (st == S_FIN);
        unique case (st)
            S_WR_GO: begin
                eng_go   = 1'b1;
                eng_word = {1'b0, cur_addr, cur_data};
            end
            S_RD_GO: begin
                eng_go   = 1'b1;
                eng_word = {1'b1, cur_addr, 8'h00};
            end
            default: begin
                eng_go   = 1'b0;
                eng_word = '0;
            end
        endcase
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i || rewrite_i));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && busy_o) |=> err_o);

    // R2
    frame_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> busy_o);

endmodule

// File: tb/test_adc_init_seq.sv
module test_adc_init_seq;

    localparam int SYS_HZ = 125_000_000;
    localparam int SPI_HZ = 12_500_000;
    localparam int HALF   = SYS_HZ / (2 * SPI_HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rewrite_i = 1'b0;
    logic [15:0] pattern_i = 16'h0000;
    logic        test_en_i = 1'b0;
    logic        miso;
    logic        sclk_o, mosi_o, cs_n_o, busy_o, done_o, err_o;

    always #4 clk = ~clk;

    adc_init_seq #(.SYS_CLK_HZ(SYS_HZ), .SCLK_HZ(SPI_HZ)) i_adc_init_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rewrite_i (rewrite_i),
        .pattern_i (pattern_i),
        .test_en_i (test_en_i),
        .miso_i    (miso),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .cs_n_o    (cs_n_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // converter model
    logic [7:0]  regs [0:127];
    logic [15:0] din = '0;
    logic [7:0]  rd_byte = '0;
    int          nb = 0;
    bit          in_frame = 0;
    logic        sclk_q = 1'b0;
    int          corrupt_addr = -1;
    logic [15:0] tr_log [0:31];
    int          tr_n = 0;
    int          bad_frames = 0;

    initial begin
        miso = 1'b0;
        for (int i = 0; i < 128; i++) regs[i] = 8'h00;
        for (int i = 0; i < 32; i++) tr_log[i] = 16'h0;
    end

    always @(sclk_o or cs_n_o) begin
        if (cs_n_o === 1'b1) begin
            if (in_frame) begin
                if (nb != 16) bad_frames++;
                else begin
                    if (!din[15]) regs[din[14:8]] = din[7:0];
                    if (tr_n < 32) tr_log[tr_n] = din;
                    tr_n++;
                end
                in_frame = 0;
            end
            nb   = 0;
            din  = '0;
            miso = 1'b0;
        end else if (cs_n_o === 1'b0) begin
            in_frame = 1;
            if (sclk_o && !sclk_q) begin
                din = {din[14:0], mosi_o};
                nb++;
            end else if (!sclk_o && sclk_q) begin
                if (nb == 8) begin
                    rd_byte = din[7] ? regs[din[6:0]] : 8'h00;
                    if (din[7] && int'(din[6:0]) == corrupt_addr) rd_byte = rd_byte ^ 8'h01;
                end
                if (nb >= 8 && nb < 16) miso = rd_byte[15-nb];
            end
        end
        sclk_q = sclk_o;
    end

    // pin monitors on falling clock edges
    int   hi_run = 0;
    int   gap_run = 1000;
    int   phase_errs = 0;
    int   gap_errs = 0;
    int   mosi_errs = 0;
    int   done_cnt = 0;
    logic p_sclk = 1'b0, p_mosi = 1'b0, p_cs = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o) hi_run++;
            else begin
                if (p_sclk && hi_run != HALF) phase_errs++;
                hi_run = 0;
            end
            if (cs_n_o) gap_run++;
            else begin
                if (p_cs && gap_run < 2 * HALF) gap_errs++;
                gap_run = 0;
            end
            if (p_sclk && sclk_o && (mosi_o !== p_mosi)) mosi_errs++;
            if (cs_n_o && sclk_o) mosi_errs++;
            if (done_o) done_cnt++;
        end
        p_sclk = sclk_o;
        p_mosi = mosi_o;
        p_cs   = cs_n_o;
    end

    task automatic finish_report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9: actual 0x0 expected 0x1");
        finish_report();
    end

    task automatic clear_log();
        tr_n = 0;
        done_cnt = 0;
        phase_errs = 0;
        gap_errs = 0;
        mosi_errs = 0;
        bad_frames = 0;
    endtask

    task automatic issue(input logic s, input logic r);
        @(negedge clk);
        start_i   = s;
        rewrite_i = r;
        @(negedge clk);
        start_i   = 1'b0;
        rewrite_i = 1'b0;
        check(busy_o === 1'b1, "R9 busy after accept", busy_o, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_o !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done_o === 1'b1, "R9 done seen", done_o, 1);
        check(busy_o === 1'b1, "R9 busy with done", busy_o, 1);
        @(negedge clk);
        check(done_o === 1'b0, "R9 done one cycle", done_o, 0);
        check(busy_o === 1'b0, "R9 idle after done", busy_o, 0);
    endtask

    task automatic check_link();
        check(bad_frames == 0, "R2 sixteen clocks per frame", bad_frames, 0);
        check(mosi_errs == 0, "R2 mode 0 timing", mosi_errs, 0);
        check(phase_errs == 0, "R3 sclk phase length", phase_errs, 0);
        check(gap_errs == 0, "R3 select gap", gap_errs, 0);
    endtask

    task automatic check_full(input logic [15:0] pat, input string tag);
        logic [15:0] exp [0:8];
        exp[0] = 16'h0080; exp[1] = 16'h0120; exp[2] = 16'h8100;
        exp[3] = 16'h0215; exp[4] = 16'h8200; exp[5] = {8'h03, pat[15:8]};
        exp[6] = 16'h8300; exp[7] = {8'h04, pat[7:0]}; exp[8] = 16'h8400;
        check(tr_n == 9, {tag, " R4 frame count"}, tr_n, 9);
        for (int i = 0; i < 9; i++)
            check(tr_log[i] == exp[i], {tag, " R4 R5 frame word"}, tr_log[i], exp[i]);
    endtask

    task automatic t_reset();
        check(cs_n_o === 1'b1 && sclk_o === 1'b0 && mosi_o === 1'b0, "R1 link idle",
              {cs_n_o, sclk_o, mosi_o}, 3'b100);
        check(busy_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0, "R1 flags clear",
              {busy_o, done_o, err_o}, 0);
    endtask

    task automatic t_full_init();
        clear_log();
        pattern_i = 16'h811F;
        issue(1'b1, 1'b0);
        wait_done();
        check_full(16'h811F, "init");
        check(err_o === 1'b0, "R8 clean run no error", err_o, 0);
        check(done_cnt == 1, "R9 single done", done_cnt, 1);
        check_link();
    endtask

    task automatic t_latch_pattern();
        clear_log();
        pattern_i = 16'hA55A;
        issue(1'b1, 1'b0);
        pattern_i = 16'h1234;
        wait_done();
        check_full(16'hA55A, "R6 latched");
        check(err_o === 1'b0, "R6 no error", err_o, 0);
    endtask

    task automatic t_rewrite(input logic te);
        logic [15:0] w;
        w = te ? 16'h0215 : 16'h0211;
        clear_log();
        test_en_i = te;
        issue(1'b0, 1'b1);
        test_en_i = ~te;
        wait_done();
        check(tr_n == 2, "R7 frame count", tr_n, 2);
        check(tr_log[0] == w, "R7 lane write", tr_log[0], w);
        check(tr_log[1] == 16'h8200, "R7 lane readback", tr_log[1], 16'h8200);
        check(err_o === 1'b0, "R7 verify ok", err_o, 0);
        check_link();
    endtask

    task automatic t_mismatch();
        clear_log();
        corrupt_addr = 3;
        pattern_i = 16'h0F0F;
        issue(1'b1, 1'b0);
        wait_done();
        check(err_o === 1'b1, "R8 mismatch flagged", err_o, 1);
        check(tr_n == 9, "R8 sequence completes", tr_n, 9);
        repeat (20) @(negedge clk);
        check(err_o === 1'b1, "R8 sticky while idle", err_o, 1);
        corrupt_addr = -1;
        clear_log();
        test_en_i = 1'b0;
        issue(1'b0, 1'b1);
        check(err_o === 1'b0, "R8 cleared on command", err_o, 0);
        wait_done();
        check(err_o === 1'b0, "R8 clean rewrite", err_o, 0);
        clear_log();
        corrupt_addr = 2;
        issue(1'b0, 1'b1);
        wait_done();
        check(err_o === 1'b1, "R8 rewrite mismatch", err_o, 1);
        corrupt_addr = -1;
    endtask

    task automatic t_busy_ignore();
        clear_log();
        pattern_i = 16'h3C5A;
        issue(1'b1, 1'b0);
        repeat (300) @(negedge clk);
        start_i = 1'b1;
        rewrite_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rewrite_i = 1'b0;
        wait_done();
        check(tr_n == 9, "R10 busy commands ignored", tr_n, 9);
        check(done_cnt == 1, "R10 one done", done_cnt, 1);
        repeat (10) @(negedge clk);
        check(busy_o === 1'b0, "R10 stays idle", busy_o, 0);
        clear_log();
        test_en_i = 1'b0;
        issue(1'b1, 1'b1);
        wait_done();
        check_full(16'h3C5A, "R10 start wins");
        check(err_o === 1'b0, "R10 clean", err_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_full_init();
        t_latch_pattern();
        t_rewrite(1'b0);
        t_rewrite(1'b1);
        t_mismatch();
        t_busy_ignore();
        repeat (5) @(negedge clk);
        finish_report();
    end

endmodule